// File: doc/BRIEF.md
# LCD Bias Ladder Switch Controller

This block drives the digital switches around the resistor ladder that makes the intermediate bias levels of a segment LCD. It has three outputs. The first is the ladder enable switch. The second is a high-drive switch, which adds the low-value resistor network in parallel for a short, programmable window after each common/segment level transition. Outside that window the ladder runs only on the high-value network, which keeps static current low. The third is a tap mask that selects which intermediate levels the current bias scheme uses.

Turning the controller off does not open the ladder at once. The open is deferred until the end of the next even frame, so every odd-plus-even frame pair seen by the glass averages to zero volts. The block keeps its own frame parity: a toggle that flips on every frame-end strobe and starts on the odd frame after reset. The pulse window is counted in prescaled clock ticks, which arrive on a strobe input. All inputs are plain single-cycle strobes or static control levels. There is no stream handshake, so back-pressure does not apply.

Top module: `lcd_ladder_ctrl`

## Requirements
- R1: On the cycle after `enable` is sampled high, `ladder_en` is 1. It stays 1 for as long as `enable` stays high.
- R2: While `enable` is low, a closed ladder stays closed until `frame_end` is sampled in an even frame. `ladder_en` is 0 from the following cycle.
- R3: Frame parity is odd after reset. It toggles on every `frame_end`, whether or not the ladder is enabled. The first `frame_end` after reset therefore ends an odd frame and does not open the ladder.
- R4: If `enable` returns high while an open is pending, the pending open is cancelled. A later even-frame end with `enable` high leaves the ladder closed.
- R5: When `level_step` is sampled with the ladder closed, a pulse of `pulse_on` = N ticks starts. `high_drive` is 1 from the next cycle. It returns to 0 on the cycle after the Nth `tick` strobe. With N = 0 it never asserts.
- R6: A `level_step` that arrives during a running pulse reloads the full count. If a `tick` arrives in the same cycle as the step, the reload wins.
- R7: `high_drive` is never 1 while `ladder_en` is 0. A `level_step` that arrives while the ladder is open starts no pulse.
- R8: `bias_sel` selects the tap mask. The mask bits are: bit0 = 1/4, bit1 = 1/3, bit2 = 1/2, bit3 = 2/3, bit4 = 3/4. The codes map as follows:
  - 00 (half bias) gives 5'b00100.
  - 01 (third bias) gives 5'b01010.
  - 10 and 11 (quarter bias) give 5'b10101.
- R9: `ladder_off` is 1 exactly when `ladder_en` is 0. After a disable it rises only when the deferred open takes effect. After reset it is 1.
- R10: `level_taps` is all zeros while the ladder is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable bit |
| pulse_on | input | 3 | High-drive window length in prescaled ticks |
| bias_sel | input | 2 | Bias scheme code |
| tick | input | 1 | Prescaled clock tick strobe |
| frame_end | input | 1 | End-of-frame strobe |
| level_step | input | 1 | Common/segment level transition strobe |
| ladder_en | output | 1 | Ladder enable switch (1 = closed) |
| high_drive | output | 1 | Low-value network switch (1 = engaged) |
| level_taps | output | 5 | Active intermediate level mask |
| ladder_off | output | 1 | Controller fully disabled |

## Verification
The bench clears `enable` in odd and in even frames. A design that opened the ladder at once, or at the end of an odd frame, would show `ladder_en` falling early and `ladder_off` rising too soon. It re-enables while an open is pending to catch a design that still opens at the next even frame end. It also restarts pulses mid-window, steps in the same cycle as a tick, and uses a zero pulse length. Together these expose off-by-one tick counts, a reload that loses to the decrement, and a stray one-cycle pulse. Steps that arrive while the ladder is open, together with random bias codes, catch high-drive leakage and mask errors.

// File: rtl/lcd_ladder_pkg.sv
package lcd_ladder_pkg;
  localparam int TAP_N = 5;
  localparam int TAP_QUARTER   = 0;
  localparam int TAP_THIRD     = 1;
  localparam int TAP_HALF      = 2;
  localparam int TAP_TWO_THIRD = 3;
  localparam int TAP_THREE_QTR = 4;

  typedef enum logic [1:0] {
    BIAS_HALF    = 2'b00,
    BIAS_THIRD   = 2'b01,
    BIAS_QUARTER = 2'b10,
    BIAS_QTR_ALT = 2'b11
  } bias_e;
endpackage

// File: rtl/lcd_frame_gate.sv
module lcd_frame_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic frame_end,
  output logic closed
);
  logic odd_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_frame <= 1'b1;
      closed    <= 1'b0;
    end else begin
      if (frame_end) odd_frame <= ~odd_frame;
      if (enable) closed <= 1'b1;
      else if (closed && frame_end && !odd_frame) closed <= 1'b0;
    end
  end

  // R1: enable closes the switch on the next cycle
  p_close_on_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> closed);
  // R2: no open except at an even frame end
  p_hold_until_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (closed && !(frame_end && !odd_frame)) |=> closed);
  // R2: open at even frame end when disabled
  p_open_at_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (closed && !enable && frame_end && !odd_frame) |=> !closed);
  // R3: parity toggles on every frame end
  p_parity_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (odd_frame != $past(odd_frame)));
endmodule

// File: rtl/lcd_pulse_timer.sv
module lcd_pulse_timer #(
  parameter int PON_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allow,
  input  logic             reload,
  input  logic [PON_W-1:0] length,
  input  logic             tick,
  output logic             running
);
  localparam logic [PON_W-1:0] ZERO = '0;
  localparam logic [PON_W-1:0] ONE  = {{(PON_W-1){1'b0}}, 1'b1};

  logic [PON_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      remain <= ZERO;
    else if (!allow)                 remain <= ZERO;
    else if (reload)                 remain <= length;
    else if (tick && remain != ZERO) remain <= remain - ONE;
  end

  assign running = (remain != ZERO);

  // R6: a step reloads the full length, even with a tick in the same cycle
  p_reload_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (allow && reload) |=> (remain == $past(length)));
  // R5: each tick consumes one count
  p_tick_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (allow && !reload && tick && remain != ZERO) |=> (remain == $past(remain) - ONE));
  // R5: without a tick or a step the count holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (allow && !reload && !tick) |=> $stable(remain));
  // R7: an open ladder leaves no count behind
  p_clear_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> (remain == ZERO));
endmodule

// File: rtl/lcd_level_decode.sv
module lcd_level_decode
  import lcd_ladder_pkg::*;
(
  input  bias_e            bias,
  input  logic             active,
  output logic [TAP_N-1:0] taps
);
  logic [TAP_N-1:0] raw;

  always_comb begin
    raw = '0;
    case (bias)
      BIAS_HALF: raw[TAP_HALF] = 1'b1;
      BIAS_THIRD: begin
        raw[TAP_THIRD]     = 1'b1;
        raw[TAP_TWO_THIRD] = 1'b1;
      end
      BIAS_QUARTER, BIAS_QTR_ALT: begin
        raw[TAP_QUARTER]   = 1'b1;
        raw[TAP_HALF]      = 1'b1;
        raw[TAP_THREE_QTR] = 1'b1;
      end
      default: raw = '0;
    endcase
  end

  assign taps = active ? raw : '0;

  // R8: third-bias taps never mix with quarter or half taps
  always_comb begin
    p_no_mixed_taps_r8: assert (!(taps[TAP_THIRD] && (taps[TAP_HALF] || taps[TAP_QUARTER])));
  end
endmodule

// File: rtl/lcd_ladder_ctrl.sv
module lcd_ladder_ctrl
  import lcd_ladder_pkg::*;
#(
  parameter int PON_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PON_W-1:0] pulse_on,
  input  logic [1:0]       bias_sel,
  input  logic             tick,
  input  logic             frame_end,
  input  logic             level_step,
  output logic             ladder_en,
  output logic             high_drive,
  output logic [TAP_N-1:0] level_taps,
  output logic             ladder_off
);
  logic closed;
  logic pulse_live;

  lcd_frame_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .frame_end (frame_end),
    .closed    (closed)
  );

  lcd_pulse_timer #(.PON_W(PON_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .allow   (closed),
    .reload  (level_step),
    .length  (pulse_on),
    .tick    (tick),
    .running (pulse_live)
  );

  lcd_level_decode u_decode (
    .bias   (bias_e'(bias_sel)),
    .active (closed),
    .taps   (level_taps)
  );

  assign ladder_en  = closed;
  assign high_drive = pulse_live && closed;
  assign ladder_off = ~closed;

  // R7: high drive requires a closed ladder
  p_hd_needs_ladder_r7: assert property (@(posedge clk) disable iff (!rst_n)
    high_drive |-> ladder_en);
  // R9: off status excludes any drive
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ladder_off |-> (!high_drive && level_taps == '0));
  // R5: zero length on a step gives no pulse
  p_zero_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (level_step && pulse_on == '0) |=> !high_drive);
endmodule

// File: tb/lcd_ladder_ctrl_tb_top.sv
module lcd_ladder_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [2:0] pulse_on = 3'd0;
  logic [1:0] bias_sel = 2'd0;
  logic tick = 1'b0, frame_end = 1'b0, level_step = 1'b0;
  logic ladder_en, high_drive, ladder_off;
  logic [4:0] level_taps;

  int total = 0;
  int bad = 0;
  bit m_en, m_odd;
  int m_cnt;

  always #2 clk = ~clk;

  lcd_ladder_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pulse_on(pulse_on),
    .bias_sel(bias_sel), .tick(tick), .frame_end(frame_end),
    .level_step(level_step), .ladder_en(ladder_en), .high_drive(high_drive),
    .level_taps(level_taps), .ladder_off(ladder_off)
  );

  function automatic logic [4:0] taps_for(logic [1:0] b);
    case (b)
      2'b00:   return 5'b00100;
      2'b01:   return 5'b01010;
      default: return 5'b10101;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R1/R2 ladder_en", ladder_en, m_en);
    check("R5 high_drive", high_drive, (m_en && m_cnt != 0));
    check("R8/R10 level_taps", level_taps, m_en ? taps_for(bias_sel) : 0);
    check("R9 ladder_off", ladder_off, !m_en);
  endtask

  task automatic cyc(bit fe, bit st, bit tk);
    bit old_en;
    frame_end = fe; level_step = st; tick = tk;
    @(posedge clk);
    old_en = m_en;
    if (enable) m_en = 1;
    else if (m_en && fe && !m_odd) m_en = 0;
    if (fe) m_odd = !m_odd;
    if (!old_en) m_cnt = 0;
    else if (st) m_cnt = pulse_on;
    else if (tk && m_cnt != 0) m_cnt--;
    @(negedge clk);
    compare_all();
    frame_end = 0; level_step = 0; tick = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; enable = 0;
    m_en = 0; m_odd = 1; m_cnt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1cd5;
    void'($urandom(seed));
    do_reset();
    check("R9 reset ladder_off", ladder_off, 1);
    check("R10 reset taps", level_taps, 0);
    check("R7 reset high_drive", high_drive, 0);

    // R3 / R2: odd end keeps ladder, even end opens it
    bias_sel = 2'b01;
    enable = 1; cyc(0, 0, 0);
    check("R1 closed after enable", ladder_en, 1);
    enable = 0; cyc(0, 0, 0);
    cyc(1, 0, 0);
    check("R3 odd frame end keeps ladder", ladder_en, 1);
    check("R9 off not yet", ladder_off, 0);
    cyc(0, 0, 0);
    cyc(1, 0, 0);
    check("R2 open at even end", ladder_en, 0);
    check("R9 off after open", ladder_off, 1);

    // R4: re-enable cancels pending open
    enable = 1; cyc(0, 0, 0);
    enable = 0; cyc(1, 0, 0);
    enable = 1; cyc(0, 0, 0);
    cyc(1, 0, 0);
    check("R4 cancelled open", ladder_en, 1);

    // R5: pulse of 3 ticks; zero length
    pulse_on = 3'd3; cyc(0, 1, 0);
    check("R5 pulse starts", high_drive, 1);
    cyc(0, 0, 1); cyc(0, 0, 0); cyc(0, 0, 1);
    check("R5 still on after 2 ticks", high_drive, 1);
    cyc(0, 0, 1);
    check("R5 off after 3rd tick", high_drive, 0);
    pulse_on = 3'd0; cyc(0, 1, 0);
    check("R5 zero length", high_drive, 0);

    // R6: restart mid pulse, step wins over same-cycle tick
    pulse_on = 3'd4; cyc(0, 1, 0);
    cyc(0, 0, 1); cyc(0, 0, 1);
    cyc(0, 1, 1);
    cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1);
    check("R6 restarted pulse still on", high_drive, 1);
    cyc(0, 0, 1);
    check("R6 restarted pulse ends", high_drive, 0);

    // R7: steps while open are ignored
    enable = 0;
    while (ladder_en) cyc(1, 0, 0);
    pulse_on = 3'd5; cyc(0, 1, 0);
    check("R7 no pulse while open", high_drive, 0);
    enable = 1; cyc(0, 0, 0);
    check("R7 no stale pulse on re-enable", high_drive, 0);

    // R8: every bias code
    for (int b = 0; b < 4; b++) begin
      bias_sel = b[1:0]; cyc(0, 0, 0);
      check("R8 bias mask", level_taps, taps_for(b[1:0]));
    end

    // Random mix against bench model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(19) == 0) enable = !enable;
      if ($urandom_range(15) == 0) bias_sel = 2'($urandom_range(3));
      if ($urandom_range(7) == 0) pulse_on = 3'($urandom_range(7));
      cyc($urandom_range(9) == 0, $urandom_range(7) == 0, $urandom_range(2) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule